// File: doc/BRIEF.md
# Clock Synthesizer Serial Programmer

This block loads a 24-bit programming word into an external clock synthesizer over two wires, a serial clock and a data line. A start pulse captures three inputs: the word, a 3-bit target-register code and a 3-bit select request. The block then sends a sequence of bit slots and finally drives two select outputs that pick which synthesizer register is active.

The slot sequence has four parts. First comes a fixed unlock preamble. A start slot follows, then the 24 payload bits and a closing stop slot. In every slot the data line holds one value while the clock falls and a second value while the clock rises. A payload bit is therefore sent as a pair of complementary values, not as one level that is sampled on one edge.

Every slot has four phases of `PHASE_CLKS` system clocks each (minimum 1): clock high with the fall value, clock low with the fall value, clock low with the rise value, then clock high with the rise value. A busy flag covers the transfer. A one-cycle done pulse marks the end. An error flag reports a select request that has no meaning.

Top module: `clksynth_prog`

## Requirements
- R1: After reset, and whenever no transfer is running, `sclkOut` and `sdataOut` are both 1, `busy` and `done` are 0, and after reset `selOut` is 00 and `err` is 0.
- R2: A transfer is 32 slots. Each slot has four phases in this order: (sclk=1, fall value), (sclk=0, fall value), (sclk=0, rise value), (sclk=1, rise value). Each phase lasts exactly `PHASE_CLKS` cycles. The first phase appears in the cycle after the start pulse is sampled.
- R3: Slots 0 to 4 carry fall=1 and rise=1 (unlock preamble). Slot 5 carries fall=0 and rise=0.
- R4: Slot 6 is the start bit, with fall=0 and rise=0.
- R5: Slots 7 to 30 carry payload bits 0 to 23, least significant first. A payload 1 is sent as fall=0, rise=1. A payload 0 is sent as fall=1, rise=0.
- R6: Payload bits 23:21 are the captured `regCode`, whatever `progWord[23:21]` held. Payload bits 20:0 are `progWord[20:0]`.
- R7: Slot 31 is the stop bit, with fall=1 and rise=1.
- R8: At the end of the transfer a select request of 0, 1, 2 or 3 drives `selOut` to 00, 01, 10 or 11 respectively, and `err` to 0.
- R9: A select request of 4 to 7 leaves `selOut` at its previous value and sets `err` to 1. `err` holds until the next transfer starts.
- R10: `busy` is 1 from the first phase through the last one. In the following cycle `busy` is 0, `done` is 1, and the new `selOut` and `err` values are visible. `done` is 0 in the cycle after that.
- R11: A start pulse while `busy` is 1 is ignored. The word, code and request captured at the start are used for the whole transfer, even if the inputs change during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a transfer when the block is idle |
| progWord | input | WORD_BITS | Programming word; bits 23:21 are replaced |
| regCode | input | CODE_BITS | Target-register code placed in bits 23:21 |
| selReq | input | SEL_BITS | Select request, 0 to 3 valid |
| sclkOut | output | 1 | Serial clock to the synthesizer |
| sdataOut | output | 1 | Serial data to the synthesizer |
| selOut | output | 2 | Select lines {S1,S0} |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Last select request was invalid |

## Verification
The assertions check on every cycle that the phase counter never reaches `PHASE_CLKS`. They also check that `done` lasts one cycle and closes a busy period, and that `selOut` and `err` change only at the end of a transfer. For `selOut` the request must also have been valid. The exact slot contents can only be shown by the bench, which rebuilds the full waveform arithmetically for every cycle. That covers the preamble, start and stop slots, the complementary payload coding in LSB-first order, and the code overwrite. The bench runs sweeps over select requests, codes and words, and it also covers a start pulse arriving in the middle of a transfer and a slower phase length.

// File: rtl/clksynth_pkg.sv
package clksynth_pkg;

  localparam int WORD_BITS_DEF = 24;
  localparam int CODE_BITS_DEF = 3;
  localparam int SEL_BITS = 3;
  localparam int PRE_HIGH_SLOTS = 5;

  localparam logic [1:0] SEL_VIDEO0 = 2'b00;
  localparam logic [1:0] SEL_VIDEO1 = 2'b01;
  localparam logic [1:0] SEL_FEATURE = 2'b10;
  localparam logic [1:0] SEL_VIDEO2 = 2'b11;

  typedef enum logic [1:0] {
    SK_HIGH = 2'd0,
    SK_LOW  = 2'd1,
    SK_DATA = 2'd2
  } slot_kind_t;

  typedef struct packed {
    logic       load;
    logic       shift;
    logic       finish;
    logic       active;
    logic [1:0] phase;
    slot_kind_t kind;
  } dp_strobe_t;

endpackage

// File: rtl/clksynth_ctrl.sv
module clksynth_ctrl
  import clksynth_pkg::*;
#(
  parameter int PHASE_CLKS = 2,
  parameter int WORD_BITS  = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output dp_strobe_t strb
);

  localparam int TOTAL_SLOTS = PRE_HIGH_SLOTS + 3 + WORD_BITS;
  localparam int SLOT_W = $clog2(TOTAL_SLOTS);
  localparam int CNT_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam int DATA_FIRST = PRE_HIGH_SLOTS + 2;
  localparam int DATA_LAST = DATA_FIRST + WORD_BITS - 1;

  logic              busyQ;
  logic              doneQ;
  logic [SLOT_W-1:0] slotQ;
  logic [1:0]        phaseQ;
  logic [CNT_W-1:0]  cntQ;

  logic       phaseEnd;
  logic       slotEnd;
  logic       lastSlot;
  slot_kind_t kind;

  assign phaseEnd = (cntQ == CNT_W'(PHASE_CLKS - 1));
  assign slotEnd  = phaseEnd && (phaseQ == 2'd3);
  assign lastSlot = (slotQ == SLOT_W'(TOTAL_SLOTS - 1));

  always_comb begin
    if (int'(slotQ) < PRE_HIGH_SLOTS) begin
      kind = SK_HIGH;
    end else if (int'(slotQ) < DATA_FIRST) begin
      kind = SK_LOW;
    end else if (int'(slotQ) <= DATA_LAST) begin
      kind = SK_DATA;
    end else begin
      kind = SK_HIGH;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      slotQ  <= '0;
      phaseQ <= 2'd0;
      cntQ   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          busyQ  <= 1'b1;
          slotQ  <= '0;
          phaseQ <= 2'd0;
          cntQ   <= '0;
        end
      end else if (phaseEnd) begin
        cntQ   <= '0;
        phaseQ <= phaseQ + 2'd1;
        if (slotEnd) begin
          if (lastSlot) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            slotQ <= slotQ + SLOT_W'(1);
          end
        end
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  assign strb.load   = !busyQ && start;
  assign strb.shift  = busyQ && slotEnd && (kind == SK_DATA);
  assign strb.finish = busyQ && slotEnd && lastSlot;
  assign strb.active = busyQ;
  assign strb.phase  = phaseQ;
  assign strb.kind   = kind;

  assign busy = busyQ;
  assign done = doneQ;

  assert_phase_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (int'(cntQ) < PHASE_CLKS));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> (!busyQ && $past(busyQ)));

endmodule

// File: rtl/clksynth_dp.sv
module clksynth_dp
  import clksynth_pkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int CODE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strobe_t           strb,
  input  logic [WORD_BITS-1:0] wordIn,
  input  logic [CODE_BITS-1:0] codeIn,
  input  logic [SEL_BITS-1:0]  selReqIn,
  output logic                 sclk,
  output logic                 sdata,
  output logic [1:0]           sel,
  output logic                 err
);

  localparam int KEEP_BITS = WORD_BITS - CODE_BITS;
  localparam logic [WORD_BITS-1:0] KEEP_MASK = {{CODE_BITS{1'b0}}, {KEEP_BITS{1'b1}}};

  logic [WORD_BITS-1:0] shiftQ;
  logic [SEL_BITS-1:0]  selReqQ;
  logic [1:0]           selQ;
  logic                 errQ;

  logic       reqValid;
  logic [1:0] reqLines;
  logic       fallVal;
  logic       riseVal;

  always_comb begin
    reqValid = 1'b1;
    case (selReqQ)
      3'd0:    reqLines = SEL_VIDEO0;
      3'd1:    reqLines = SEL_VIDEO1;
      3'd2:    reqLines = SEL_FEATURE;
      3'd3:    reqLines = SEL_VIDEO2;
      default: begin
        reqLines = selQ;
        reqValid = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      selReqQ <= '0;
      selQ    <= SEL_VIDEO0;
      errQ    <= 1'b0;
    end else begin
      if (strb.load) begin
        shiftQ  <= (wordIn & KEEP_MASK) | (WORD_BITS'(codeIn) << KEEP_BITS);
        selReqQ <= selReqIn;
        errQ    <= 1'b0;
      end else if (strb.shift) begin
        shiftQ <= shiftQ >> 1;
      end
      if (strb.finish) begin
        selQ <= reqLines;
        errQ <= !reqValid;
      end
    end
  end

  always_comb begin
    case (strb.kind)
      SK_LOW: begin
        fallVal = 1'b0;
        riseVal = 1'b0;
      end
      SK_DATA: begin
        fallVal = !shiftQ[0];
        riseVal = shiftQ[0];
      end
      default: begin
        fallVal = 1'b1;
        riseVal = 1'b1;
      end
    endcase
  end

  assign sclk  = !strb.active || (strb.phase == 2'd0) || (strb.phase == 2'd3);
  assign sdata = !strb.active ? 1'b1 : (strb.phase[1] ? riseVal : fallVal);
  assign sel   = selQ;
  assign err   = errQ;

  assert_sel_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selQ) |-> ($past(strb.finish) && ($past(selReqQ[2]) == 1'b0)));

  assert_err_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> ($past(strb.finish) && ($past(selReqQ[2]) == 1'b1)));

endmodule

// File: rtl/clksynth_prog.sv
module clksynth_prog
  import clksynth_pkg::*;
#(
  parameter int PHASE_CLKS = 2,
  parameter int WORD_BITS  = WORD_BITS_DEF,
  parameter int CODE_BITS  = CODE_BITS_DEF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic [WORD_BITS-1:0] progWord,
  input  logic [CODE_BITS-1:0] regCode,
  input  logic [SEL_BITS-1:0]  selReq,
  output logic                 sclkOut,
  output logic                 sdataOut,
  output logic [1:0]           selOut,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);

  dp_strobe_t strb;

  clksynth_ctrl #(
    .PHASE_CLKS(PHASE_CLKS),
    .WORD_BITS (WORD_BITS)
  ) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .start(startPulse),
    .busy (busy),
    .done (done),
    .strb (strb)
  );

  clksynth_dp #(
    .WORD_BITS(WORD_BITS),
    .CODE_BITS(CODE_BITS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wordIn  (progWord),
    .codeIn  (regCode),
    .selReqIn(selReq),
    .sclk    (sclkOut),
    .sdata   (sdataOut),
    .sel     (selOut),
    .err     (err)
  );

endmodule

// File: tb/clksynth_prog_tb_top.sv
module clksynth_prog_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        startA;
  logic        startB;
  logic [23:0] word;
  logic [2:0]  code;
  logic [2:0]  sr;

  logic sclkA, sdataA, busyA, doneA, errA;
  logic sclkB, sdataB, busyB, doneB, errB;
  logic [1:0] selA, selB;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  logic [1:0] prevSel [2];

  clksynth_prog #(.PHASE_CLKS(1)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startA), .progWord(word),
    .regCode(code), .selReq(sr), .sclkOut(sclkA), .sdataOut(sdataA),
    .selOut(selA), .busy(busyA), .done(doneA), .err(errA)
  );

  clksynth_prog #(.PHASE_CLKS(3)) dutSlow_i (
    .clk(clk), .rstN(rstN), .startPulse(startB), .progWord(word),
    .regCode(code), .selReq(sr), .sclkOut(sclkB), .sdataOut(sdataB),
    .selOut(selB), .busy(busyB), .done(doneB), .err(errB)
  );

  logic [6:0] obsA, obsB;
  assign obsA = {sclkA, sdataA, selA, busyA, doneA, errA};
  assign obsB = {sclkB, sdataB, selB, busyB, doneB, errB};

  function automatic logic [6:0] getObs(input int which);
    return (which == 0) ? obsA : obsB;
  endfunction

  function automatic logic [1:0] expPins(input int slot, input int ph, input logic [23:0] pay);
    logic f, r;
    if (slot < 5) begin
      f = 1'b1; r = 1'b1;
    end else if (slot < 7) begin
      f = 1'b0; r = 1'b0;
    end else if (slot < 31) begin
      r = pay[slot - 7];
      f = !r;
    end else begin
      f = 1'b1; r = 1'b1;
    end
    return {(ph == 0 || ph == 3), (ph < 2) ? f : r};
  endfunction

  function automatic string reqOf(input int slot);
    if (slot < 6) return "R3";
    if (slot == 6) return "R4";
    if (slot < 28) return "R5";
    if (slot < 31) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runXfer(input int which, input logic [23:0] w, input logic [2:0] c,
                         input logic [2:0] s, input bit mid);
    int p;
    int firstBad;
    logic [23:0] pay;
    logic [6:0] o;
    logic [2:0] gotPins;
    logic [2:0] wantPins;
    logic [1:0] expP;
    logic [1:0] es;
    bit ee;
    string req;
    p = (which == 0) ? 1 : 3;
    pay = {c, w[20:0]};
    firstBad = -1;
    gotPins = '0;
    wantPins = '0;
    @(negedge clk);
    word = w; code = c; sr = s;
    if (which == 0) startA = 1'b1; else startB = 1'b1;
    @(negedge clk);
    startA = 1'b0; startB = 1'b0;
    for (int n = 0; n < 128 * p; n++) begin
      o = getObs(which);
      expP = expPins(n / (4 * p), (n / p) % 4, pay);
      if (firstBad < 0 && ({o[6:5], o[2]} !== {expP, 1'b1})) begin
        firstBad = n;
        gotPins = {o[6:5], o[2]};
        wantPins = {expP, 1'b1};
      end
      if (mid && n == 10) begin
        word = ~w; code = ~c; sr = s ^ 3'b101;
        if (which == 0) startA = 1'b1; else startB = 1'b1;
      end
      if (mid && n == 11) begin
        startA = 1'b0; startB = 1'b0;
      end
      @(negedge clk);
    end
    if (firstBad < 0) req = mid ? "R11" : "R2";
    else req = mid ? "R11" : reqOf(firstBad / (4 * p));
    check(firstBad < 0, req, $sformatf("waveform {sclk,sdata,busy} at cycle %0d", firstBad),
          int'(gotPins), int'(wantPins));
    es = (s < 3'd4) ? s[1:0] : prevSel[which];
    ee = (s >= 3'd4);
    o = getObs(which);
    check(o[1] == 1'b1 && o[2] == 1'b0, "R10", "{done,busy} at end", int'({o[1], o[2]}), 2);
    check(o[4:3] == es, (s < 3'd4) ? "R8" : "R9", "selOut at done", int'(o[4:3]), int'(es));
    check(o[0] == ee, "R9", "err at done", int'(o[0]), int'(ee));
    check(o[6:5] == 2'b11, "R1", "idle lines after transfer", int'(o[6:5]), 3);
    prevSel[which] = es;
    @(negedge clk);
    o = getObs(which);
    check(o[1] == 1'b0, "R10", "done one cycle only", int'(o[1]), 0);
  endtask

  initial begin
    logic [23:0] words [4];
    words[0] = 24'h000000;
    words[1] = 24'hFFFFFF;
    words[2] = 24'h5A3C96;
    words[3] = 24'h800001;
    rstN = 1'b0; startA = 1'b0; startB = 1'b0;
    word = '0; code = '0; sr = '0;
    prevSel[0] = 2'b00; prevSel[1] = 2'b00;
    repeat (3) @(negedge clk);
    check(obsA == 7'b1100000, "R1", "reset state fast", int'(obsA), 7'h60);
    check(obsB == 7'b1100000, "R1", "reset state slow", int'(obsB), 7'h60);
    rstN = 1'b1;
    @(negedge clk);
    check(obsA == 7'b1100000, "R1", "idle after reset", int'(obsA), 7'h60);
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 4; k++) begin
          runXfer(0, words[k] ^ {8'(c * 37), 8'(s * 11), 8'(k * 5)}, 3'(c), 3'(s), 1'b0);
        end
      end
    end
    runXfer(0, 24'h13579B, 3'd5, 3'd2, 1'b1);
    runXfer(0, 24'hFEDCBA, 3'd1, 3'd6, 1'b1);
    runXfer(1, 24'hC0FFEE, 3'd2, 3'd3, 1'b0);
    runXfer(1, 24'h0F0F0F, 3'd7, 3'd7, 1'b0);
    runXfer(1, 24'h2468AC, 3'd0, 3'd1, 1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule